// File: doc/BRIEF.md
# Audio Master-Clock Ratio Detector

This block runs on an audio converter's master clock and counts how many master-clock cycles fall between consecutive rising edges of the frame clock. It sorts that count into one of seven legal ratios (128, 192, 256, 384, 512, 768 or 1152 times the sample rate), then decides the sampling-speed mode and the internal divide that the digital filter path should use. A ratio is trusted only after two frame periods in a row give the same class. The filter datapath is held in power-down until the first trusted ratio, and again whenever the frame clock stops.

Two selection schemes exist. With the automatic selector set, the measured ratio alone picks the speed. With it cleared, a two-bit speed code picks the speed and the measured ratio is only checked against the set that speed allows. A build-time variant replaces the configuration write port with a single strap pin. That pin chooses between automatic selection and fixed normal speed, and the variant refuses the two lowest ratios.

Top module: `mclk_ratio_detector`

## Requirements
- R1: After reset `pd_o`=1, `auto_o`=1, `speed_o`=00, `ratio_o`=7 (none), `err_o`=0 and `lost_o`=0.
- R2: A period of N master-clock cycles between frame-clock rising edges is classified as the legal ratio R when N lies within R-2 to R+2. On `ratio_o` the codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1152 and 7=none.
- R3: A ratio is accepted only when two consecutive measured periods give the same class. The first rising edge after reset, or after a loss, starts a measurement but yields none. `pd_o` falls on the first acceptance, and `ratio_o` is never 7 while `pd_o` is 0.
- R4: With automatic selection, an accepted 512, 768 or 1152 gives `speed_o`=00 (normal), 256 or 384 gives 01 (double), and 128 or 192 gives 10 (quad).
- R5: With automatic selection, the stored speed code has no effect on `speed_o`.
- R6: With manual selection, `speed_o` takes the stored speed code. The code accepts only these ratios: 256, 384, 512, 768 and 1152 for 00; 128, 192, 256 and 384 for 01; 128 and 192 for 10; none for 11. `speed_o` never reads 11.
- R7: A period that matches no legal ratio, or an accepted ratio that the current mode does not allow, sets `err_o` and leaves `speed_o` and `ratio_o` unchanged. The next successful acceptance clears `err_o`.
- R8: If no frame-clock rising edge is seen for 2048 master-clock cycles, `lost_o` and `pd_o` are set. `lost_o` clears at the next measured period, and `pd_o` clears at the next acceptance.
- R9: In the strap-pin variant, the internal speed code is fixed at 00. `mode_pin`=1 selects automatic mode and `mode_pin`=0 selects manual normal speed, `auto_o` follows `mode_pin`, and the configuration write port is ignored.
- R10: In the strap-pin variant, ratios 128 and 192 are never accepted in either mode and raise `err_o`.
- R11: In the default variant, a cycle with `cfg_we`=1 loads `cfg_auto` into the automatic selector, which is read back on `auto_o`, and loads `cfg_speed` into the speed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| frame_clk | input | 1 | Frame clock, asynchronous, synchronised inside |
| cfg_we | input | 1 | Configuration write strobe (default variant) |
| cfg_auto | input | 1 | Automatic-selector value to write |
| cfg_speed | input | 2 | Speed code to write |
| mode_pin | input | 1 | Strap pin (strap-pin variant): 1 automatic, 0 normal |
| pd_o | output | 1 | Datapath power-down |
| auto_o | output | 1 | Effective automatic-selector state |
| speed_o | output | 2 | Speed: 00 normal, 01 double, 10 quad |
| ratio_o | output | 3 | Accepted ratio code, 7 when none |
| err_o | output | 1 | Illegal or disallowed ratio seen |
| lost_o | output | 1 | Frame clock missing |

## Verification
Ratio classification and the mode gate meet in the same cycle. The edge that completes the second matching period both classifies the ratio and checks it against the current selection, so one update has to produce either acceptance or an error, never both. The bench provokes this by presenting stable, legal ratios that the active manual code or the strap variant forbids, such as 512 under double speed, 192 under the reserved code, or 128 on the strap variant. It then checks that `err_o` rises while `speed_o` and `ratio_o` keep their earlier values. A second collision, between a timeout and the recovery measurement that follows, is judged by checking when `lost_o` and `pd_o` release after a gap.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    typedef enum logic [2:0] {
        RT_128  = 3'd0,
        RT_192  = 3'd1,
        RT_256  = 3'd2,
        RT_384  = 3'd3,
        RT_512  = 3'd4,
        RT_768  = 3'd5,
        RT_1152 = 3'd6,
        RT_NONE = 3'd7
    } ratio_e;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    localparam int unsigned NUM_RATIOS = 7;

    typedef struct packed {
        logic   auto_en;
        speed_e spd_cfg;
        speed_e speed;
        ratio_e ratio;
        ratio_e prev;
        logic   pd;
        logic   err;
        logic   lost;
    } det_state_t;

    // Nominal cycles per frame for a ratio index.
    function automatic int unsigned ratio_cycles(int unsigned idx);
        if (idx == NUM_RATIOS - 1) return 1152;
        return ((idx % 2) == 0) ? (128 << (idx / 2)) : (192 << (idx / 2));
    endfunction

    function automatic ratio_e classify(int unsigned n, int unsigned tol);
        ratio_e res;
        res = RT_NONE;
        for (int unsigned i = 0; i < NUM_RATIOS; i++) begin
            if ((n + tol >= ratio_cycles(i)) && (n <= ratio_cycles(i) + tol))
                res = ratio_e'(3'(i));
        end
        return res;
    endfunction

    function automatic speed_e auto_speed(ratio_e r);
        case (r)
            RT_128, RT_192: return SPD_QUAD;
            RT_256, RT_384: return SPD_DOUBLE;
            default:        return SPD_NORMAL;
        endcase
    endfunction

    function automatic logic manual_ok(ratio_e r, speed_e s);
        case (s)
            SPD_NORMAL: return (r >= RT_256) && (r <= RT_1152);
            SPD_DOUBLE: return (r <= RT_384);
            SPD_QUAD:   return (r <= RT_192);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/mrd_period_meter.sv
module mrd_period_meter
    import mrd_pkg::*;
#(
    parameter int unsigned TIMEOUT = 2048,
    parameter int unsigned TOL     = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rise_i,
    output logic   meas_stb_o,
    output ratio_e meas_code_o,
    output logic   tout_o
);
    localparam int unsigned     CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             have_q, have_d;

    always_comb begin
        cnt_d  = cnt_q;
        have_d = have_q;
        if (rise_i) begin
            cnt_d  = '0;
            have_d = 1'b1;
        end else begin
            if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST)  have_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            have_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            have_q <= have_d;
        end
    end

    assign meas_stb_o  = rise_i && have_q;
    assign meas_code_o = classify(int'(cnt_q) + 1, TOL);
    assign tout_o      = !rise_i && (cnt_q == LAST);
endmodule

// File: rtl/mclk_ratio_detector.sv
module mclk_ratio_detector
    import mrd_pkg::*;
#(
    parameter bit          PARALLEL    = 1'b0,
    parameter int unsigned TIMEOUT     = 2048,
    parameter int unsigned TOL         = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_clk,
    input  logic       cfg_we,
    input  logic       cfg_auto,
    input  logic [1:0] cfg_speed,
    input  logic       mode_pin,
    output logic       pd_o,
    output logic       auto_o,
    output logic [1:0] speed_o,
    output logic [2:0] ratio_o,
    output logic       err_o,
    output logic       lost_o
);
    logic   rise;
    logic   meas_stb;
    ratio_e meas_code;
    logic   tout;

    det_state_t st_q, st_d;
    logic       eff_auto;
    speed_e     eff_spd;
    speed_e     target;
    logic       allowed;

    mrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (frame_clk),
        .rise_o   (rise)
    );

    mrd_period_meter #(.TIMEOUT(TIMEOUT), .TOL(TOL)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .meas_stb_o  (meas_stb),
        .meas_code_o (meas_code),
        .tout_o      (tout)
    );

    always_comb begin
        eff_auto = PARALLEL ? mode_pin   : st_q.auto_en;
        eff_spd  = PARALLEL ? SPD_NORMAL : st_q.spd_cfg;
        target   = eff_auto ? auto_speed(meas_code) : eff_spd;
        allowed  = eff_auto ? 1'b1 : manual_ok(meas_code, eff_spd);
        if (PARALLEL && (meas_code <= RT_192)) allowed = 1'b0;

        st_d = st_q;
        if (!PARALLEL && cfg_we) begin
            st_d.auto_en = cfg_auto;
            st_d.spd_cfg = speed_e'(cfg_speed);
        end
        if (tout) begin
            st_d.lost = 1'b1;
            st_d.pd   = 1'b1;
            st_d.prev = RT_NONE;
        end else if (meas_stb) begin
            st_d.lost = 1'b0;
            st_d.prev = meas_code;
            if (meas_code == RT_NONE) begin
                st_d.err = 1'b1;
            end else if (meas_code == st_q.prev) begin
                if (allowed) begin
                    st_d.speed = target;
                    st_d.ratio = meas_code;
                    st_d.pd    = 1'b0;
                    st_d.err   = 1'b0;
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.auto_en <= 1'b1;
            st_q.spd_cfg <= SPD_NORMAL;
            st_q.speed   <= SPD_NORMAL;
            st_q.ratio   <= RT_NONE;
            st_q.prev    <= RT_NONE;
            st_q.pd      <= 1'b1;
            st_q.err     <= 1'b0;
            st_q.lost    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_o    = st_q.pd;
    assign auto_o  = eff_auto;
    assign speed_o = st_q.speed;
    assign ratio_o = st_q.ratio;
    assign err_o   = st_q.err;
    assign lost_o  = st_q.lost;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
    parameter bit PARALLEL = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_o,
    input logic [1:0] speed_o,
    input logic [2:0] ratio_o,
    input logic       err_o,
    input logic       lost_o
);
    AST_NO_RSVD_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        speed_o != 2'b11); // R6

    AST_QUAD_LOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_o && speed_o == 2'b10) |-> (ratio_o <= 3'd1)); // R6

    AST_LIVE_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_o |-> (ratio_o != 3'd7)); // R3

    AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($stable(speed_o) && $stable(ratio_o))); // R7

    AST_LOST_POWERS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> pd_o); // R8

    AST_STRAP_NO_LOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (PARALLEL && !pd_o) |-> (ratio_o >= 3'd2)); // R10
endmodule

bind mclk_ratio_detector mrd_checker #(.PARALLEL(PARALLEL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_o    (pd_o),
    .speed_o (speed_o),
    .ratio_o (ratio_o),
    .err_o   (err_o),
    .lost_o  (lost_o)
);

// File: tb/test_mclk_ratio_detector.sv
module test_mclk_ratio_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_auto = 1'b0;
    logic [1:0] cfg_speed = 2'b00;
    logic       mode_pin = 1'b1;

    logic       pd_a, auto_a, err_a, lost_a;
    logic [1:0] speed_a;
    logic [2:0] ratio_a;
    logic       pd_b, auto_b, err_b, lost_b;
    logic [1:0] speed_b;
    logic [2:0] ratio_b;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mclk_ratio_detector #(.PARALLEL(1'b0)) i_mclk_ratio_detector (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
        .cfg_we(cfg_we), .cfg_auto(cfg_auto), .cfg_speed(cfg_speed),
        .mode_pin(mode_pin),
        .pd_o(pd_a), .auto_o(auto_a), .speed_o(speed_a), .ratio_o(ratio_a),
        .err_o(err_a), .lost_o(lost_a)
    );

    mclk_ratio_detector #(.PARALLEL(1'b1)) i_mclk_ratio_detector_strap (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
        .cfg_we(cfg_we), .cfg_auto(cfg_auto), .cfg_speed(cfg_speed),
        .mode_pin(mode_pin),
        .pd_o(pd_b), .auto_o(auto_b), .speed_o(speed_b), .ratio_o(ratio_b),
        .err_o(err_b), .lost_o(lost_b)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic frames(input int n, input int count);
        for (int i = 0; i < count; i++) begin
            frame_clk = 1'b0;
            repeat (n / 2) @(negedge clk);
            frame_clk = 1'b1;
            repeat (n - n / 2) @(negedge clk);
        end
    endtask

    task automatic write_cfg(input logic a, input logic [1:0] s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_auto = a; cfg_speed = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 pd", pd_a, 1);
        chk("R1 auto", auto_a, 1);
        chk("R1 speed", speed_a, 0);
        chk("R1 ratio", ratio_a, 7);
        chk("R1 err", err_a, 0);
        chk("R1 lost", lost_a, 0);
        chk("R9 strap auto follows pin", auto_b, 1);
    endtask

    task automatic t_lock;
        frames(512, 2);
        chk("R3 one period is not enough", pd_a, 1);
        frames(512, 1);
        chk("R3 pd released", pd_a, 0);
        chk("R3 speed", speed_a, 0);
        chk("R2 ratio 512", ratio_a, 4);
    endtask

    task automatic t_tolerance;
        frames(514, 4);
        chk("R2 514 matches 512", ratio_a, 4);
        chk("R2 no err", err_a, 0);
        frames(517, 4);
        chk("R7 err on 517", err_a, 1);
        chk("R7 speed kept", speed_a, 0);
        chk("R7 ratio kept", ratio_a, 4);
        chk("R7 pd kept", pd_a, 0);
    endtask

    task automatic t_auto_map;
        frames(256, 4);
        chk("R4 256 double", speed_a, 1);
        chk("R7 err cleared", err_a, 0);
        frames(128, 4);
        chk("R4 128 quad", speed_a, 2);
        chk("R2 ratio 128", ratio_a, 0);
        frames(1152, 4);
        chk("R4 1152 normal", speed_a, 0);
        chk("R2 ratio 1152", ratio_a, 6);
    endtask

    task automatic t_auto_ignores;
        write_cfg(1'b1, 2'b10);
        frames(768, 4);
        chk("R5 code ignored", speed_a, 0);
        chk("R5 ratio 768", ratio_a, 5);
        chk("R11 auto readback", auto_a, 1);
    endtask

    task automatic t_manual;
        write_cfg(1'b0, 2'b01);
        chk("R11 auto cleared", auto_a, 0);
        frames(384, 4);
        chk("R6 manual double", speed_a, 1);
        chk("R6 ratio 384", ratio_a, 3);
        frames(512, 4);
        chk("R6 512 refused in double", err_a, 1);
        chk("R7 speed kept", speed_a, 1);
        chk("R7 ratio kept", ratio_a, 3);
        write_cfg(1'b0, 2'b10);
        frames(192, 4);
        chk("R6 manual quad", speed_a, 2);
        chk("R6 ratio 192", ratio_a, 1);
        chk("R6 err clear", err_a, 0);
        write_cfg(1'b0, 2'b11);
        frames(192, 4);
        chk("R6 reserved code refuses", err_a, 1);
        chk("R6 speed kept", speed_a, 2);
    endtask

    task automatic t_strap;
        mode_pin = 1'b0;
        frames(256, 4);
        chk("R9 pin low normal", speed_b, 0);
        chk("R9 ratio 256", ratio_b, 2);
        chk("R9 pd", pd_b, 0);
        chk("R9 err", err_b, 0);
        chk("R9 auto low", auto_b, 0);
        mode_pin = 1'b1;
        frames(128, 4);
        chk("R10 128 refused", err_b, 1);
        chk("R10 ratio kept", ratio_b, 2);
        chk("R10 speed kept", speed_b, 0);
        frames(256, 4);
        chk("R9 pin high auto", speed_b, 1);
    endtask

    task automatic t_timeout;
        write_cfg(1'b1, 2'b00);
        frames(512, 4);
        chk("R8 locked before gap", pd_a, 0);
        frame_clk = 1'b0;
        repeat (1700) @(negedge clk);
        chk("R8 no loss yet", lost_a, 0);
        repeat (300) @(negedge clk);
        chk("R8 lost", lost_a, 1);
        chk("R8 pd on loss", pd_a, 1);
        frames(512, 3);
        chk("R8 lost cleared", lost_a, 0);
        chk("R8 pd released", pd_a, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_tolerance();
        t_auto_map();
        t_auto_ignores();
        t_manual();
        t_strap();
        t_timeout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule